// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block watches every access a processor makes and decides whether it falls inside one of two guarded address windows without the right to do so. Software programs four address points (two per window), one address mask per window, a per-window enable and per-window permission bits through a small write port. A single selector decides whether the group guards instruction fetches, checking the execute right, or operand accesses, checking the read and write rights. All checking is gated by one protection-enable bit. When that bit is clear, the group never objects to an access.

Each access is presented for one cycle with a strobe, an instruction/operand flag, a write flag and the address. One clock later the block answers with a single-cycle violation pulse when the access is refused. The first refused access is captured, with its address and kind, in a status record. That record stays put until software writes the clear location.

Top module: `mpu_range_guard`

## Requirements
- R1: After reset every register is zero: no violation is reported, the status record is empty (valid 0, address 0, kind 0), and protection is off.
- R2: While the protection-enable bit (control bit 0) is 0, no access raises a violation, whatever the windows, enables and permission bits hold.
- R3: Window 0 spans point 0 (location 1) to point 1 (location 2) and window 1 spans point 2 (location 3) to point 3 (location 4), with both bounds inclusive: an address equal to either bound hits, and one below the lower or above the upper bound misses.
- R4: Bits set in a window's mask (mask 0 at location 5, mask 1 at location 6) are left out of both bound comparisons.
- R5: With the type select (control bit 1) at 0, only instruction fetches are checked, against each window's execute bit (control bit 4 for window 0, bit 7 for window 1).
- R6: With the type select at 1, only operand accesses are checked: reads against the read bits (bits 5 and 8) and writes against the write bits (bits 6 and 9).
- R7: An access of the kind the type select does not name is never flagged.
- R8: A window takes part only while its enable bit is set (bit 2 for window 0, bit 3 for window 1), and an access that hits no enabled window is allowed.
- R9: An access that hits both enabled windows is allowed when either window grants the needed right.
- R10: A refused access raises the violation output for exactly the one cycle after the access strobe, and the output stays low in any cycle that follows a cycle without a strobe.
- R11: The first violation stores its address and kind (0 execute, 1 read, 2 write) in the status record and sets the status valid flag. Later violations leave the record unchanged until it is cleared.
- R12: Any write to location 7 empties the status record. A violation in the same cycle as that write is stored in the emptied record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register location |
| cfg_wdata | input | ADDR_W | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_instr | input | 1 | 1 for an instruction fetch, 0 for an operand access |
| acc_write | input | 1 | 1 for an operand write, 0 for a read |
| acc_addr | input | ADDR_W | Access address |
| viol | output | 1 | Violation pulse, one cycle after the refused access |
| fault_valid | output | 1 | Status record holds a fault |
| fault_addr | output | ADDR_W | Address of the captured fault |
| fault_kind | output | 2 | Kind of the captured fault |

## Verification
The bench builds the block with a 16-bit address, which keeps window bounds short and puts the mask behaviour within easy reach. A mask on the top nibble lets an address far outside the programmed bounds still hit. The 16-bit width still leaves room for all ten control bits and for addresses just below and above each bound. The runs cover both type-select settings, overlapping windows with split rights, and a clear that lands in the same cycle as a new fault.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic exec;
    logic rd;
    logic wr;
  } perm_t;

  localparam int unsigned NUM_WIN   = 2;
  localparam int unsigned NUM_PTS   = 2 * NUM_WIN;
  localparam int unsigned LOC_W     = 3;
  localparam int unsigned PERM_BITS = 3;

  // register locations
  localparam logic [LOC_W-1:0] LOC_CTRL  = 3'd0;
  localparam logic [LOC_W-1:0] LOC_PT0   = 3'd1;
  localparam logic [LOC_W-1:0] LOC_MASK0 = 3'd5;
  localparam logic [LOC_W-1:0] LOC_CLEAR = 3'd7;

  // control bit positions
  localparam int unsigned CB_PROT  = 0;
  localparam int unsigned CB_TYPE  = 1;
  localparam int unsigned CB_WEN0  = 2;
  localparam int unsigned CB_PERM0 = CB_WEN0 + NUM_WIN;
  localparam int unsigned CTRL_W   = CB_PERM0 + PERM_BITS * NUM_WIN;

endpackage

// File: rtl/mpu_guard_regs.sv
module mpu_guard_regs
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [LOC_W-1:0]                wr_loc,
  input  logic [ADDR_W-1:0]               wr_data,
  output logic                            prot_en,
  output logic                            type_sel,
  output logic [NUM_WIN-1:0]              win_en,
  output perm_t [NUM_WIN-1:0]             win_perm,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_lo,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_hi,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_mask,
  output logic                            clr_pulse
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we;

  always_comb begin
    ctrl_we = wr_en && (wr_loc == LOC_CTRL);
    ctrl_d  = ctrl_q;
    if (ctrl_we) ctrl_d = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign prot_en   = ctrl_q[CB_PROT];
  assign type_sel  = ctrl_q[CB_TYPE];
  assign clr_pulse = wr_en && (wr_loc == LOC_CLEAR);

  logic [NUM_PTS-1:0][ADDR_W-1:0] pt_q;
  logic [NUM_PTS-1:0][ADDR_W-1:0] pt_d;

  for (genvar g = 0; g < NUM_PTS; g++) begin : g_pt
    localparam logic [LOC_W-1:0] MY_LOC = LOC_PT0 + LOC_W'(g);
    logic pt_we;
    always_comb begin
      pt_we   = wr_en && (wr_loc == MY_LOC);
      pt_d[g] = pt_we ? wr_data : pt_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pt_q[g] <= '0;
      else        pt_q[g] <= pt_d[g];
    end
  end

  logic [NUM_WIN-1:0][ADDR_W-1:0] mk_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] mk_d;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [LOC_W-1:0] MK_LOC = LOC_MASK0 + LOC_W'(w);
    logic mk_we;
    always_comb begin
      mk_we   = wr_en && (wr_loc == MK_LOC);
      mk_d[w] = mk_we ? wr_data : mk_q[w];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mk_q[w] <= '0;
      else        mk_q[w] <= mk_d[w];
    end

    assign win_en[w]        = ctrl_q[CB_WEN0 + w];
    assign win_perm[w].exec = ctrl_q[CB_PERM0 + PERM_BITS * w];
    assign win_perm[w].rd   = ctrl_q[CB_PERM0 + PERM_BITS * w + 1];
    assign win_perm[w].wr   = ctrl_q[CB_PERM0 + PERM_BITS * w + 2];
    assign win_lo[w]        = pt_q[2 * w];
    assign win_hi[w]        = pt_q[2 * w + 1];
    assign win_mask[w]      = mk_q[w];
  end

endmodule

// File: rtl/mpu_range_cmp.sv
module mpu_range_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);

  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] a_m, lo_m, hi_m;
  logic              ge_lo, le_hi;

  always_comb begin
    keep  = ~mask;
    a_m   = addr & keep;
    lo_m  = lo & keep;
    hi_m  = hi & keep;
    ge_lo = (a_m >= lo_m);
    le_hi = (a_m <= hi_m);
    hit   = ge_lo && le_hi;
  end

endmodule

// File: rtl/mpu_perm_eval.sv
module mpu_perm_eval
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_instr,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                prot_en,
  input  logic                type_sel,
  input  logic [NUM_WIN-1:0]  win_en,
  input  logic [NUM_WIN-1:0]  win_hit,
  input  perm_t [NUM_WIN-1:0] win_perm,
  input  logic                clr_pulse,
  output logic                viol,
  output logic                fault_valid,
  output logic [ADDR_W-1:0]   fault_addr,
  output logic [1:0]          fault_kind
);

  acc_kind_e         kind;
  logic              type_ok;
  logic [NUM_WIN-1:0] hit_en, grant;
  logic              viol_d, viol_q;
  logic              fv_d, fv_q;
  logic [ADDR_W-1:0] fa_d, fa_q;
  acc_kind_e         fk_d, fk_q;
  logic              cap;

  always_comb begin
    if (acc_instr)      kind = KIND_EXEC;
    else if (acc_write) kind = KIND_WRITE;
    else                kind = KIND_READ;
    type_ok = acc_instr ? !type_sel : type_sel;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_grant
    always_comb begin
      hit_en[w] = win_en[w] && win_hit[w];
      unique case (kind)
        KIND_EXEC:  grant[w] = hit_en[w] && win_perm[w].exec;
        KIND_READ:  grant[w] = hit_en[w] && win_perm[w].rd;
        default:    grant[w] = hit_en[w] && win_perm[w].wr;
      endcase
    end
  end

  always_comb begin
    viol_d = acc_valid && prot_en && type_ok && (|hit_en) && !(|grant);
    cap    = viol_d && (!fv_q || clr_pulse);
    fv_d   = fv_q;
    fa_d   = fa_q;
    fk_d   = fk_q;
    if (cap) begin
      fv_d = 1'b1;
      fa_d = acc_addr;
      fk_d = kind;
    end else if (clr_pulse) begin
      fv_d = 1'b0;
      fa_d = '0;
      fk_d = KIND_EXEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      fv_q   <= 1'b0;
      fa_q   <= '0;
      fk_q   <= KIND_EXEC;
    end else begin
      viol_q <= viol_d;
      fv_q   <= fv_d;
      fa_q   <= fa_d;
      fk_q   <= fk_d;
    end
  end

  assign viol        = viol_q;
  assign fault_valid = fv_q;
  assign fault_addr  = fa_q;
  assign fault_kind  = fk_q;

endmodule

// File: rtl/mpu_range_guard.sv
module mpu_range_guard
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_instr,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              viol,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_kind
);

  logic                           prot_en;
  logic                           type_sel;
  logic [NUM_WIN-1:0]             win_en;
  perm_t [NUM_WIN-1:0]            win_perm;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_lo, win_hi, win_mask;
  logic                           clr_pulse;
  logic [NUM_WIN-1:0]             win_hit;

  mpu_guard_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_loc    (cfg_addr),
    .wr_data   (cfg_wdata),
    .prot_en   (prot_en),
    .type_sel  (type_sel),
    .win_en    (win_en),
    .win_perm  (win_perm),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .win_mask  (win_mask),
    .clr_pulse (clr_pulse)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    mpu_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .addr (acc_addr),
      .lo   (win_lo[w]),
      .hi   (win_hi[w]),
      .mask (win_mask[w]),
      .hit  (win_hit[w])
    );
  end

  mpu_perm_eval #(.ADDR_W(ADDR_W)) u_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_instr   (acc_instr),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .prot_en     (prot_en),
    .type_sel    (type_sel),
    .win_en      (win_en),
    .win_hit     (win_hit),
    .win_perm    (win_perm),
    .clr_pulse   (clr_pulse),
    .viol        (viol),
    .fault_valid (fault_valid),
    .fault_addr  (fault_addr),
    .fault_kind  (fault_kind)
  );

endmodule

// File: rtl/mpu_range_guard_chk.sv
module mpu_range_guard_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_addr,
  input logic              acc_valid,
  input logic              acc_instr,
  input logic              prot_en,
  input logic              type_sel,
  input logic              viol,
  input logic              fault_valid,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [1:0]        fault_kind
);

  logic clr_w;
  assign clr_w = cfg_we && (cfg_addr == 3'd7);

  // R2: protection off means no violation next cycle
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !prot_en) |=> !viol);

  // R7: the unselected access kind is never flagged
  a_r7_foreign_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_instr == type_sel)) |=> !viol);

  // R10: no strobe, no pulse
  a_r10_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !viol);

  // R11: a pulse always leaves a filled status record
  a_r11_pulse_records: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> fault_valid);

  // R11: the record only fills together with a pulse
  a_r11_fill_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_valid) |-> viol);

  // R11: a filled record holds until cleared
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !clr_w) |=> (fault_valid && $stable(fault_addr) && $stable(fault_kind)));

  // R11: kind code stays within the three defined values
  a_r11_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fault_kind != 2'd3);

endmodule

bind mpu_range_guard mpu_range_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .acc_valid   (acc_valid),
  .acc_instr   (acc_instr),
  .prot_en     (prot_en),
  .type_sel    (type_sel),
  .viol        (viol),
  .fault_valid (fault_valid),
  .fault_addr  (fault_addr),
  .fault_kind  (fault_kind)
);

// File: tb/mpu_range_guard_bench.sv
module mpu_range_guard_bench;

  localparam int unsigned AW = 16;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic          acc_valid, acc_instr, acc_write;
  logic [AW-1:0] acc_addr;
  logic          viol, fault_valid;
  logic [AW-1:0] fault_addr;
  logic [1:0]    fault_kind;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic last_viol;

  mpu_range_guard #(.ADDR_W(AW)) u_mpu_range_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_instr(acc_instr),
    .acc_write(acc_write), .acc_addr(acc_addr), .viol(viol),
    .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_kind(fault_kind)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // control word fields
  localparam logic [15:0] PROT = 16'h0001, TYP = 16'h0002;
  localparam logic [15:0] EN0 = 16'h0004, EN1 = 16'h0008;
  localparam logic [15:0] X0 = 16'h0010, RD0 = 16'h0020, WR0 = 16'h0040;
  localparam logic [15:0] X1 = 16'h0080, RD1 = 16'h0100, WR1 = 16'h0200;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] loc, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = loc; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // access lasts one cycle; last_viol is the pulse seen after it
  task automatic acc(input logic instr, input logic w, input logic [AW-1:0] a);
    @(negedge clk);
    acc_valid = 1; acc_instr = instr; acc_write = w; acc_addr = a;
    @(negedge clk);
    acc_valid = 0;
    last_viol = viol;
  endtask

  task automatic clear_status();
    wr(3'd7, '0);
  endtask

  task automatic t_reset();
    chk("R1 viol", viol, 0);
    chk("R1 fault_valid", fault_valid, 0);
    chk("R1 fault_addr", fault_addr, 0);
    chk("R1 fault_kind", fault_kind, 0);
    acc(1, 0, 16'h0000);
    chk("R1 no viol at reset config", last_viol, 0);
  endtask

  task automatic t_disabled();
    wr(3'd1, 16'h1000); wr(3'd2, 16'h1FFF);
    wr(3'd0, EN0 | TYP);
    acc(1, 0, 16'h1800);
    chk("R2 off instr", last_viol, 0);
    acc(0, 1, 16'h1800);
    chk("R2 off write", last_viol, 0);
    chk("R2 no record", fault_valid, 0);
  endtask

  task automatic t_exec();
    wr(3'd3, 16'h3000); wr(3'd4, 16'h30FF);
    wr(3'd0, PROT | EN0 | EN1 | X0);
    acc(1, 0, 16'h1800);
    chk("R5 exec granted", last_viol, 0);
    acc(1, 0, 16'h3010);
    chk("R5 exec refused", last_viol, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", viol, 0);
    chk("R11 valid", fault_valid, 1);
    chk("R11 addr", fault_addr, 16'h3010);
    chk("R11 kind exec", fault_kind, 0);
    acc(1, 0, 16'h3020);
    chk("R11 second viol", last_viol, 1);
    chk("R11 sticky addr", fault_addr, 16'h3010);
    clear_status();
    chk("R12 cleared", fault_valid, 0);
    acc(0, 0, 16'h3010);
    chk("R7 operand in exec mode", last_viol, 0);
  endtask

  task automatic t_bounds();
    acc(1, 0, 16'h3000);
    chk("R3 lower bound hit", last_viol, 1);
    acc(1, 0, 16'h30FF);
    chk("R3 upper bound hit", last_viol, 1);
    acc(1, 0, 16'h2FFF);
    chk("R3 below lower miss", last_viol, 0);
    acc(1, 0, 16'h3100);
    chk("R3 above upper miss", last_viol, 0);
    acc(1, 0, 16'h5000);
    chk("R8 outside all windows", last_viol, 0);
    wr(3'd0, PROT | EN0 | X0);
    acc(1, 0, 16'h3010);
    chk("R8 window disabled", last_viol, 0);
    clear_status();
  endtask

  task automatic t_operand();
    wr(3'd0, PROT | TYP | EN0 | EN1 | RD0);
    acc(0, 0, 16'h1800);
    chk("R6 read granted", last_viol, 0);
    acc(0, 1, 16'h1800);
    chk("R6 write refused", last_viol, 1);
    chk("R11 kind write", fault_kind, 2);
    clear_status();
    acc(0, 0, 16'h3010);
    chk("R6 read refused", last_viol, 1);
    chk("R11 kind read", fault_kind, 1);
    clear_status();
    acc(1, 0, 16'h3010);
    chk("R7 instr in operand mode", last_viol, 0);
  endtask

  task automatic t_mask();
    acc(0, 0, 16'h7010);
    chk("R4 no mask miss", last_viol, 0);
    wr(3'd6, 16'hF000);
    acc(0, 0, 16'h7010);
    chk("R4 masked hit", last_viol, 1);
    chk("R4 record addr", fault_addr, 16'h7010);
    clear_status();
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_overlap();
    wr(3'd3, 16'h1000); wr(3'd4, 16'h1FFF);
    wr(3'd0, PROT | TYP | EN0 | EN1 | RD0 | RD1 | WR1);
    acc(0, 1, 16'h1800);
    chk("R9 one window grants", last_viol, 0);
    wr(3'd0, PROT | TYP | EN0 | EN1 | RD0 | RD1);
    acc(0, 1, 16'h1800);
    chk("R9 neither grants", last_viol, 1);
  endtask

  task automatic t_clear_race();
    // record holds 0x1800; clear together with a new fault
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'd7; cfg_wdata = '0;
    acc_valid = 1; acc_instr = 0; acc_write = 1; acc_addr = 16'h1234;
    @(negedge clk);
    cfg_we = 0; acc_valid = 0;
    chk("R12 race viol", viol, 1);
    chk("R12 race valid", fault_valid, 1);
    chk("R12 race addr", fault_addr, 16'h1234);
    @(negedge clk);
    chk("R10 idle no pulse", viol, 0);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    acc_valid = 0; acc_instr = 0; acc_write = 0; acc_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_exec();
    t_bounds();
    t_operand();
    t_mask();
    t_overlap();
    t_clear_race();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule